// File: doc/BRIEF.md
# Wrapping Burst Sequencer

This block runs fixed-length read and write bursts to an external burstable memory that sits on one of several chip selects. A system master hands it one request at a time: a start word address, a word count, a wrap flag, a direction and the chip select to use. The block then drives the chip-select and read/write strobes, counts the data beats, and presents a word address for each beat. That address either climbs in a straight line from the start address or wraps inside an aligned window.

Each chip select has its own timing settings. These are the device page length (the size of the device's buffer), the idle cycles before the strobes assert, the cycles per beat, the cycles the strobes are held after the final beat, and whether a wait input from the memory may stretch a beat. A request longer than the page is cut to the page length and flagged. A request shorter than the page produces only the beats it asks for. The block captures the chip select's settings when it accepts a request, so software can reprogram them at any time without disturbing an access in flight.

Top module: `wrap_burst_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_cs`, `mem_rd`, `mem_wr`, `beat_ack` and `burst_err` are 0. Every chip select's settings are cleared: page code 0, wait monitoring off, and all three timing counts 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the access has fully ended. While `req_ready` is 1, no strobe is active and `beat_ack` is 0.
- R3: After acceptance, all strobes stay low for (lead + 1) cycles. Then bit `req_cs` of `mem_cs` asserts, together with `mem_wr` when `req_write` is 1 or `mem_rd` when it is 0. At most one chip-select bit is ever high.
- R4: With wait monitoring off, every beat lasts (interval + 1) cycles. `beat_ack` is 1 only in the final cycle of each beat. `mem_addr` holds one value for the whole beat and is 0 outside beats.
- R5: With wait monitoring on, a beat that has reached its final cycle is held for as long as `mem_wait` is 1. `beat_ack` is 1 only in a cycle where `mem_wait` is 0.
- R6: With wait monitoring off for the active chip select, `mem_wait` has no effect on any output.
- R7: The number of beats is `req_len`, except that 0 gives one beat, and a value above the page length gives exactly page-length beats. In that last case `burst_err` is 1 from the cycle after acceptance until the next acceptance; otherwise it is 0 over that span.
- R8: The 2-bit page code sets the page length: 0 gives 4 words, 1 gives 8 words, and both 2 and 3 give 16 words.
- R9: In a non-wrapping burst, beat k (counting from 0) carries address (start + k) modulo 2^ADDR_W.
- R10: In a wrapping burst, W is the smallest power of two that is at least the beat count. Beat k carries (start with its low log2(W) bits cleared) OR ((start + k) mod W).
- R11: After the final beat's `beat_ack`, the strobes stay asserted for (tail + 1) cycles. They drop in the same cycle that `req_ready` returns to 1.
- R12: A settings write (`cfg_we`) to any chip select is accepted in any cycle. An access uses the settings its chip select held just before the acceptance edge. A write in the acceptance cycle, or during the access, takes effect from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write enable for one chip select's settings |
| cfg_sel | input | CS_W | Chip select being programmed |
| cfg_page | input | 2 | Page code (0: 4, 1: 8, 2 or 3: 16 words) |
| cfg_wait_en | input | 1 | Enable wait-input monitoring |
| cfg_lead | input | TIM_W | Cycles before strobe assertion, minus one |
| cfg_ivl | input | TIM_W | Cycles per beat, minus one |
| cfg_tail | input | TIM_W | Cycles strobes stay on after the last beat, minus one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_cs | input | CS_W | Target chip select |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Requested word count |
| req_wrap | input | 1 | 1 for a wrapping burst |
| req_write | input | 1 | 1 for write, 0 for read |
| mem_wait | input | 1 | Memory wait input |
| mem_cs | output | NUM_CS | Chip-select strobes, active high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Word address of the current beat |
| beat_ack | output | 1 | Current beat completes this cycle |
| burst_err | output | 1 | Last accepted request was clipped |

## Verification
Two things can land in the same clock cycle: a settings write and the acceptance of a request on the same chip select. The bench forces this by raising `cfg_we` and `req_valid` together. It then checks that the burst length and timing follow the old settings and that the following request follows the new ones. A second overlap is a settings write to the active chip select partway through a burst, which must leave that burst's beat spacing unchanged. A reference model in the bench predicts every output on every cycle. The directed checks also compare the total access length and the beat count with closed-form values.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   // width of every programmable cycle count
   parameter int unsigned TIM_W = 4;
   // beat counter width: holds 0..16
   localparam int unsigned BCNT_W = 5;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LEAD = 2'd1,
      S_BEAT = 2'd2,
      S_TAIL = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic [1:0]       page;
      logic             wait_en;
      logic [TIM_W-1:0] lead;
      logic [TIM_W-1:0] ivl;
      logic [TIM_W-1:0] tail;
   } cs_cfg_t;

   // page code to buffer depth in words; code 3 falls back to 16
   function automatic logic [BCNT_W-1:0] page_words(input logic [1:0] code);
      case (code)
         2'd0:    return BCNT_W'(4);
         2'd1:    return BCNT_W'(8);
         default: return BCNT_W'(16);
      endcase
   endfunction

   // smallest power of two not below the beat count
   function automatic logic [BCNT_W-1:0] wrap_window(input logic [BCNT_W-1:0] beats);
      logic [BCNT_W-1:0] w;
      w = BCNT_W'(1);
      for (int i = 0; i < BCNT_W - 1; i++) begin
         if (w < beats) w = w << 1;
      end
      return w;
   endfunction

endpackage

// File: rtl/wbs_cfg_bank.sv
module wbs_cfg_bank
   import wbs_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   localparam int unsigned CS_W = $clog2(NUM_CS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [CS_W-1:0] wr_sel,
   input  cs_cfg_t         wr_data,
   input  logic [CS_W-1:0] rd_sel,
   output cs_cfg_t         rd_data
);

   cs_cfg_t regs_all [NUM_CS];

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      cs_cfg_t r_q;
      always_ff @(posedge clk) begin
         if (rst) r_q <= '0;
         else if (wr_en && (wr_sel == CS_W'(g))) r_q <= wr_data;
      end
      assign regs_all[g] = r_q;
   end

   // value before any write of this cycle
   assign rd_data = regs_all[rd_sel];

endmodule

// File: rtl/wbs_addr_gen.sv
module wbs_addr_gen
   import wbs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter bit          WRAP_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] start,
   input  logic [BCNT_W-1:0] idx,
   input  logic              wrap,
   input  logic [BCNT_W-1:0] window,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] lin;
   assign lin = start + ADDR_W'(idx);

   if (WRAP_EN) begin : g_wrap
      logic [ADDR_W-1:0] mask;
      assign mask = ADDR_W'(window) - ADDR_W'(1);
      assign addr = wrap ? ((start & ~mask) | (lin & mask)) : lin;
   end else begin : g_lin
      logic unused_w;
      assign unused_w = wrap ^ (^window);
      assign addr     = lin;
   end

endmodule

// File: rtl/wrap_burst_seq.sv
module wrap_burst_seq
   import wbs_pkg::*;
#(
   parameter int unsigned NUM_CS  = 4,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LEN_W   = 5,
   parameter bit          WRAP_EN = 1'b1,
   localparam int unsigned CS_W   = $clog2(NUM_CS),
   localparam int unsigned TW     = wbs_pkg::TIM_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [CS_W-1:0]   cfg_sel,
   input  logic [1:0]        cfg_page,
   input  logic              cfg_wait_en,
   input  logic [TW-1:0]     cfg_lead,
   input  logic [TW-1:0]     cfg_ivl,
   input  logic [TW-1:0]     cfg_tail,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              req_wrap,
   input  logic              req_write,
   input  logic              mem_wait,
   output logic [NUM_CS-1:0] mem_cs,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              beat_ack,
   output logic              burst_err
);

   localparam int unsigned CMP_W = (LEN_W > BCNT_W) ? LEN_W : BCNT_W;

   if (NUM_CS < 2 || (1 << CS_W) != NUM_CS) begin : g_bad_cs
      $error("NUM_CS must be a power of two, at least 2");
   end
   if (ADDR_W < BCNT_W) begin : g_bad_addr
      $error("ADDR_W too narrow for a 16-word page");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   cs_cfg_t     wr_cfg, sel_cfg, cfg_q;
   seq_state_e  st_q;
   logic [TW-1:0]     cnt_q;
   logic [BCNT_W-1:0] idx_q, nb_q, win_q, beats_d;
   logic [ADDR_W-1:0] start_q, gen_addr;
   logic [CS_W-1:0]   cs_q;
   logic              wrap_q, wr_q, err_q, clip_err;
   logic [CMP_W-1:0]  len_x, pg_x;
   logic              in_beat, active, beat_done, last_beat, wait_en_q;

   always_comb begin
      wr_cfg.page    = cfg_page;
      wr_cfg.wait_en = cfg_wait_en;
      wr_cfg.lead    = cfg_lead;
      wr_cfg.ivl     = cfg_ivl;
      wr_cfg.tail    = cfg_tail;
   end

   wbs_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_sel),
      .wr_data (wr_cfg),
      .rd_sel  (req_cs),
      .rd_data (sel_cfg)
   );

   // clip the request to the device page
   always_comb begin
      len_x    = CMP_W'(req_len);
      pg_x     = CMP_W'(page_words(sel_cfg.page));
      clip_err = (len_x > pg_x);
      if (len_x == '0)   beats_d = BCNT_W'(1);
      else if (clip_err) beats_d = BCNT_W'(pg_x);
      else               beats_d = BCNT_W'(len_x);
   end

   assign in_beat   = (st_q == S_BEAT);
   assign active    = in_beat || (st_q == S_TAIL);
   assign wait_en_q = cfg_q.wait_en;
   assign beat_done = in_beat && (cnt_q == cfg_q.ivl) && !(wait_en_q && mem_wait);
   assign last_beat = (idx_q == nb_q - BCNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= S_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         nb_q    <= '0;
         win_q   <= '0;
         start_q <= '0;
         cs_q    <= '0;
         wrap_q  <= 1'b0;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
         cfg_q   <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (req_valid) begin
               st_q    <= S_LEAD;
               cnt_q   <= '0;
               idx_q   <= '0;
               nb_q    <= beats_d;
               win_q   <= wrap_window(beats_d);
               start_q <= req_addr;
               cs_q    <= req_cs;
               wrap_q  <= req_wrap;
               wr_q    <= req_write;
               err_q   <= clip_err;
               cfg_q   <= sel_cfg;
            end
            S_LEAD: begin
               if (cnt_q == cfg_q.lead) begin
                  st_q  <= S_BEAT;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + TW'(1);
            end
            S_BEAT: begin
               if (beat_done) begin
                  cnt_q <= '0;
                  if (last_beat) st_q <= S_TAIL;
                  else           idx_q <= idx_q + BCNT_W'(1);
               end else if (cnt_q != cfg_q.ivl) begin
                  cnt_q <= cnt_q + TW'(1);
               end
            end
            S_TAIL: begin
               if (cnt_q == cfg_q.tail) st_q <= S_IDLE;
               else                     cnt_q <= cnt_q + TW'(1);
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   wbs_addr_gen #(.ADDR_W(ADDR_W), .WRAP_EN(WRAP_EN)) u_addr (
      .start  (start_q),
      .idx    (idx_q),
      .wrap   (wrap_q),
      .window (win_q),
      .addr   (gen_addr)
   );

   always_comb begin
      mem_cs = '0;
      if (active) mem_cs[cs_q] = 1'b1;
   end

   assign req_ready = (st_q == S_IDLE);
   assign mem_rd    = active && !wr_q;
   assign mem_wr    = active && wr_q;
   assign mem_addr  = in_beat ? gen_addr : '0;
   assign beat_ack  = beat_done;
   assign burst_err = err_q;

endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic [NUM_CS-1:0] mem_cs,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_wait,
   input logic              beat_ack,
   input logic              burst_err,
   input logic              in_beat,
   input logic              wait_en_q
);

   assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mem_cs));

   assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   assert_strobe_pair_R3: assert property (@(posedge clk) disable iff (rst)
      (mem_cs != '0) == (mem_rd || mem_wr));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (mem_cs == '0 && !beat_ack));

   assert_ack_in_access_R4: assert property (@(posedge clk) disable iff (rst)
      beat_ack |-> (mem_cs != '0));

   assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (in_beat && !beat_ack) |=> $stable(mem_addr));

   assert_wait_blocks_ack_R5: assert property (@(posedge clk) disable iff (rst)
      (beat_ack && wait_en_q) |-> !mem_wait);

   assert_err_held_R7: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && !$past(req_ready)) |-> $stable(burst_err));

endmodule

bind wrap_burst_seq wbs_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_ready (req_ready),
   .mem_cs    (mem_cs),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .mem_wait  (mem_wait),
   .beat_ack  (beat_ack),
   .burst_err (burst_err),
   .in_beat   (in_beat),
   .wait_en_q (wait_en_q)
);

// File: tb/sim_wrap_burst_seq.sv
module sim_wrap_burst_seq;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_sel = '0, cfg_page = '0;
   logic       cfg_wait_en = 1'b0;
   logic [3:0] cfg_lead = '0, cfg_ivl = '0, cfg_tail = '0;
   logic       req_valid = 1'b0, req_wrap = 1'b0, req_write = 1'b0;
   logic [1:0] req_cs = '0;
   logic [15:0] req_addr = '0;
   logic [4:0] req_len = '0;
   logic       mem_wait = 1'b0;
   logic       req_ready, mem_rd, mem_wr, beat_ack, burst_err;
   logic [3:0] mem_cs;
   logic [15:0] mem_addr;

   wrap_burst_seq u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, ack_cnt = 0;
   bit wait_mode = 1'b0;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;
   always @(posedge clk) begin
      #3 mem_wait <= wait_mode ? 1'($urandom % 2) : 1'b0;
   end
   always @(negedge clk) if (!rst && beat_ack) ack_cnt++;

   // ---------------- reference model ----------------
   int m_page[4], m_wen[4], m_lead[4], m_ivl[4], m_tail[4];
   int m_st, m_cnt, m_idx, m_err;
   int s_cs, s_wen, s_lead, s_ivl, s_tail, s_start, s_wrap, s_wr, s_nb, s_win;

   function automatic int words_of(int code);
      return (code == 0) ? 4 : (code == 1) ? 8 : 16;
   endfunction

   function automatic int model_addr(int k);
      int lin;
      lin = s_start + k;
      if (s_wrap != 0) return ((s_start & ~(s_win - 1)) | (lin & (s_win - 1))) & 16'hFFFF;
      return lin & 16'hFFFF;
   endfunction

   always @(negedge clk) begin
      int e_ack, e_act, e_cs, e_addr, pg;
      if (rst) begin
         for (int i = 0; i < 4; i++) begin
            m_page[i] = 0; m_wen[i] = 0; m_lead[i] = 0; m_ivl[i] = 0; m_tail[i] = 0;
         end
         m_st = 0; m_cnt = 0; m_idx = 0; m_err = 0;
         s_cs = 0; s_wen = 0; s_lead = 0; s_ivl = 0; s_tail = 0;
         s_start = 0; s_wrap = 0; s_wr = 0; s_nb = 1; s_win = 1;
      end else begin
         e_act  = (m_st == 2 || m_st == 3) ? 1 : 0;
         e_cs   = e_act ? (1 << s_cs) : 0;
         e_ack  = (m_st == 2 && m_cnt == s_ivl && !(s_wen != 0 && mem_wait)) ? 1 : 0;
         e_addr = (m_st == 2) ? model_addr(m_idx) : 0;
         chk(req_ready == (m_st == 0), "R2 ready", req_ready, m_st == 0);
         chk(mem_cs == e_cs, (m_st == 3) ? "R11 chip select" : "R3 chip select", mem_cs, e_cs);
         chk(mem_rd == (e_act && !s_wr), "R3 read strobe", mem_rd, e_act && !s_wr);
         chk(mem_wr == (e_act && s_wr), "R3 write strobe", mem_wr, e_act && s_wr);
         chk(beat_ack == e_ack, (s_wen != 0) ? "R5 beat ack" : "R4 beat ack", beat_ack, e_ack);
         chk(mem_addr == e_addr, (s_wrap != 0) ? "R10 address" : "R9 address", mem_addr, e_addr);
         chk(burst_err == m_err, "R7 error flag", burst_err, m_err);
         case (m_st)
            0: if (req_valid) begin
               s_cs = req_cs; s_wen = m_wen[req_cs]; s_lead = m_lead[req_cs];
               s_ivl = m_ivl[req_cs]; s_tail = m_tail[req_cs];
               s_start = req_addr; s_wrap = req_wrap; s_wr = req_write;
               pg = words_of(m_page[req_cs]);
               m_err = (req_len > pg) ? 1 : 0;
               s_nb = (req_len == 0) ? 1 : (req_len > pg) ? pg : int'(req_len);
               s_win = 1;
               while (s_win < s_nb) s_win = s_win * 2;
               m_st = 1; m_cnt = 0; m_idx = 0;
            end
            1: if (m_cnt == s_lead) begin m_st = 2; m_cnt = 0; end else m_cnt++;
            2: if (e_ack != 0) begin
                  m_cnt = 0;
                  if (m_idx == s_nb - 1) m_st = 3; else m_idx++;
               end else if (m_cnt != s_ivl) m_cnt++;
            default: if (m_cnt == s_tail) m_st = 0; else m_cnt++;
         endcase
         if (cfg_we) begin
            m_page[cfg_sel] = cfg_page; m_wen[cfg_sel] = cfg_wait_en;
            m_lead[cfg_sel] = cfg_lead; m_ivl[cfg_sel] = cfg_ivl; m_tail[cfg_sel] = cfg_tail;
         end
      end
   end

   // ---------------- stimulus ----------------
   bit pend = 1'b0;
   logic [1:0] p_sel, p_page;
   logic [3:0] p_lead, p_ivl, p_tail;

   task automatic set_cfg(logic [1:0] s, logic [1:0] pg, bit we, logic [3:0] ld, logic [3:0] iv, logic [3:0] tl);
      cfg_sel = s; cfg_page = pg; cfg_wait_en = we; cfg_lead = ld; cfg_ivl = iv; cfg_tail = tl;
   endtask

   task automatic cfg_write(logic [1:0] s, logic [1:0] pg, bit we, logic [3:0] ld, logic [3:0] iv, logic [3:0] tl);
      set_cfg(s, pg, we, ld, iv, tl);
      cfg_we = 1'b1;
      @(posedge clk); #2;
      cfg_we = 1'b0;
   endtask

   task automatic burst(int cs, int addr, int len, bit wrap, bit wr,
                        int exp_nb, int exp_dur, bit exp_err, string tag);
      int t0, dur;
      while (!req_ready) begin @(posedge clk); #2; end
      req_cs = 2'(cs); req_addr = 16'(addr); req_len = 5'(len);
      req_wrap = wrap; req_write = wr; req_valid = 1'b1;
      if (pend) begin
         set_cfg(p_sel, p_page, 1'b0, p_lead, p_ivl, p_tail);
         cfg_we = 1'b1;
      end
      ack_cnt = 0;
      @(posedge clk); #2;
      req_valid = 1'b0; cfg_we = 1'b0; pend = 1'b0;
      t0 = cyc;
      do begin @(posedge clk); #2; end while (!req_ready);
      dur = cyc - t0;
      chk(ack_cnt == exp_nb, {tag, " beat count"}, ack_cnt, exp_nb);
      if (exp_dur >= 0) chk(dur == exp_dur, {tag, " access length"}, dur, exp_dur);
      else              chk(dur >= -exp_dur, {tag, " minimum access length"}, dur, -exp_dur);
      chk(burst_err == exp_err, {tag, " error flag"}, burst_err, exp_err);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      @(posedge clk); #2;
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(mem_cs == 4'd0, "R1 chip select after reset", mem_cs, 0);
      chk(!mem_rd && !mem_wr, "R1 strobes after reset", mem_rd | mem_wr, 0);
      chk(beat_ack == 1'b0, "R1 ack after reset", beat_ack, 0);
      chk(burst_err == 1'b0, "R1 error after reset", burst_err, 0);
      // R1 default settings: 4-word page, all counts zero
      burst(0, 16'h0010, 16, 1'b0, 1'b0, 4, 1 + 4 + 1, 1'b1, "R1 default page");

      // R8 page codes
      cfg_write(2'd1, 2'd1, 1'b0, 4'd2, 4'd1, 4'd1);
      cfg_write(2'd2, 2'd2, 1'b0, 4'd0, 4'd0, 4'd2);
      cfg_write(2'd3, 2'd3, 1'b0, 4'd1, 4'd2, 4'd0);
      burst(1, 16'h0040, 16, 1'b0, 1'b0, 8, 3 + 16 + 2, 1'b1, "R8 code1");
      burst(2, 16'h0100, 16, 1'b1, 1'b0, 16, 1 + 16 + 3, 1'b0, "R8 code2");
      burst(3, 16'h0020, 31, 1'b0, 1'b1, 16, 2 + 48 + 1, 1'b1, "R8 code3 write");

      // R7 short requests
      burst(2, 16'h0200, 0, 1'b0, 1'b0, 1, 1 + 1 + 3, 1'b0, "R7 zero length");
      burst(1, 16'h0300, 3, 1'b0, 1'b1, 3, 3 + 6 + 2, 1'b0, "R7 short");

      // R9 address rollover, R10 wrap windows
      burst(2, 16'hFFFE, 4, 1'b0, 1'b0, 4, 1 + 4 + 3, 1'b0, "R9 rollover");
      burst(1, 16'h0105, 8, 1'b1, 1'b0, 8, 3 + 16 + 2, 1'b0, "R10 wrap8");
      burst(1, 16'h0236, 3, 1'b1, 1'b1, 3, 3 + 6 + 2, 1'b0, "R10 wrap3");

      // R6 wait toggling ignored while monitoring is off
      wait_mode = 1'b1;
      burst(1, 16'h0033, 8, 1'b1, 1'b0, 8, 3 + 16 + 2, 1'b0, "R6 wait ignored");
      // R5 wait stretches beats
      cfg_write(2'd0, 2'd2, 1'b1, 4'd1, 4'd0, 4'd0);
      burst(0, 16'h0400, 8, 1'b1, 1'b0, 8, -(2 + 8 + 1), 1'b0, "R5 wait on");
      burst(0, 16'h0500, 16, 1'b0, 1'b1, 16, -(2 + 16 + 1), 1'b0, "R5 wait on long");
      wait_mode = 1'b0;

      // R12 write during a burst does not change it
      fork
         burst(1, 16'h0600, 4, 1'b0, 1'b0, 4, 3 + 8 + 2, 1'b0, "R12 mid-burst write");
         begin
            repeat (4) @(posedge clk);
            #2 cfg_write(2'd1, 2'd1, 1'b0, 4'd2, 4'd3, 4'd1);
         end
      join
      burst(1, 16'h0600, 4, 1'b0, 1'b0, 4, 3 + 16 + 2, 1'b0, "R12 new interval");

      // R12 write in the acceptance cycle
      pend = 1'b1; p_sel = 2'd2; p_page = 2'd0; p_lead = 4'd0; p_ivl = 4'd2; p_tail = 4'd2;
      burst(2, 16'h0700, 8, 1'b1, 1'b0, 8, 1 + 8 + 3, 1'b0, "R12 same-cycle old");
      burst(2, 16'h0700, 8, 1'b1, 1'b0, 4, 1 + 12 + 3, 1'b1, "R12 same-cycle new");

      repeat (3) @(posedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule